// File: doc/BRIEF.md
# Filtered Quadrature Front End

This block sits between an incremental encoder and a position counter. It takes the two phase inputs of the encoder and produces a one-cycle count-enable pulse and a direction level. The counter itself is not part of the block. An 8-bit reloadable prescaler divides the master clock into a sample strobe. Both phase inputs are synchronized and then filtered at that strobe rate. The filtered phases are decoded at single, double or quadruple resolution. A bypass mode treats phase A as a plain count input and phase B as a direction level.

Counting can be blocked in two ways: by an input-enable bit, or by a gate input when gate mode is selected. An index input with selectable polarity produces one pulse per index event. That pulse can either follow activation of the index directly or be aligned to the next decoded count step. A sticky noise flag records filtered glitches and illegal double transitions. It stays set until an explicit clear.

Top module: `quad_front`

## Requirements
- R1: While reset is asserted, cnt_en, idx_pulse and noise_err are 0, cnt_up is 1 (up), a_filt and b_filt are 0, and sample_tick is 1 because the prescaler holds 0.
- R2: A psc_load pulse stores psc_value as n and restarts the prescaler from n. From then on, sample_tick is high for one clock in every n+1 clocks, and n = 0 gives a strobe on every clock. After n = 255 is loaded, the first two strobes come exactly 255 and 511 clocks after the load edge.
- R3: Each phase passes through a two-flop synchronizer. Its filtered output takes a new level only at the second consecutive strobe on which the synchronized input shows that level. A pulse seen on only one strobe leaves a_filt and b_filt unchanged.
- R4: In x4 mode (mode = 2'b11), every change of a filtered phase gives one cnt_en pulse, one clock after the filtered output changes. The step is up (cnt_up = 1) when A changes to differ from B or when B changes to equal A, so the forward sequence of (A,B) is 00, 10, 11, 01.
- R5: In x2 mode (mode = 2'b10), only changes of filtered A give a count, with the same direction rule as in x4 mode.
- R6: In x1 mode (mode = 2'b01), only changes of filtered A made while filtered B is 0 give a count. A rising is up and A falling is down, so one full forward cycle gives one count.
- R7: In bypass mode (mode = 2'b00), the filter is not in the count path. Each rising edge of synchronized A gives one cnt_en pulse, and cnt_up takes the synchronized B level (1 = up).
- R8: No cnt_en pulse is produced while ab_enable is 0, or while gate_mode is 1 and the synchronized gate_in is 0. cnt_up holds its last value while counting is blocked.
- R9: In a decode mode, noise_err sets in two cases: when a filtered phase changes and that same phase was also the last one to change, or when both filtered phases change in the same clock. A change of both phases at once gives no count. noise_err stays set until err_clear, and a new error in the same clock takes priority over the clear.
- R10: With idx_sync = 1 in a decode mode, each activation of the index produces exactly one idx_pulse, in the clock after the first counted step that occurs while the index is active. The index is active high when idx_pol = 1 and active low when idx_pol = 0. This works for both quarter-cycle and half-cycle index widths.
- R11: With idx_sync = 0, or in bypass mode, idx_pulse goes high for one clock, one clock after the synchronized index becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psc_load | input | 1 | Load psc_value as the prescaler divisor |
| psc_value | input | PSC_W | Prescaler divisor n (rate = clk/(n+1)) |
| mode | input | 2 | 00 bypass, 01 x1, 10 x2, 11 x4 |
| ab_enable | input | 1 | 1 allows phase inputs to count |
| gate_mode | input | 1 | 1 makes gate_in a count gate |
| gate_in | input | 1 | Count gate, high allows counting |
| a_in | input | 1 | Phase A, or count input in bypass mode |
| b_in | input | 1 | Phase B, or direction in bypass mode |
| idx_in | input | 1 | Index input |
| idx_pol | input | 1 | 1 active-high index, 0 active-low |
| idx_sync | input | 1 | 1 aligns the index pulse to a count step |
| err_clear | input | 1 | Clears the noise flag |
| sample_tick | output | 1 | Filter sample strobe |
| a_filt | output | 1 | Filtered phase A |
| b_filt | output | 1 | Filtered phase B |
| cnt_en | output | 1 | One-clock count pulse |
| cnt_up | output | 1 | Direction of the latest counted step (1 = up) |
| idx_pulse | output | 1 | One-clock index event |
| noise_err | output | 1 | Sticky noise flag |

## Verification
A corrupted prescaler count shows at sample_tick within one strobe period. It then shifts the clock in which a_filt or b_filt change, which delays cnt_en by the same number of cycles. A wrong filter pending bit or a wrong last-channel record shows within two strobes: as an extra or missing filtered transition, or as a noise_err value that differs from the one the input history predicts. A bad index arming state appears as a missing or duplicated idx_pulse at the first counted step after the index activates. The bench compares every output on every clock against a behavioural model, so any such divergence is reported in the cycle it first appears.

// File: rtl/quad_front.sv
module quad_front #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             psc_load,
  input  logic [PSC_W-1:0] psc_value,
  input  logic [1:0]       mode,
  input  logic             ab_enable,
  input  logic             gate_mode,
  input  logic             gate_in,
  input  logic             a_in,
  input  logic             b_in,
  input  logic             idx_in,
  input  logic             idx_pol,
  input  logic             idx_sync,
  input  logic             err_clear,
  output logic             sample_tick,
  output logic             a_filt,
  output logic             b_filt,
  output logic             cnt_en,
  output logic             cnt_up,
  output logic             idx_pulse,
  output logic             noise_err
);
  localparam logic [PSC_W-1:0] PSC_ZERO = '0;
  localparam logic [PSC_W-1:0] PSC_ONE  = PSC_W'(1);

  logic [1:0] a_s, b_s, i_s, g_s;
  logic       a_sd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      a_s <= '0; b_s <= '0; i_s <= '0; g_s <= '0; a_sd <= 1'b0;
    end else begin
      a_s  <= {a_s[0], a_in};
      b_s  <= {b_s[0], b_in};
      i_s  <= {i_s[0], idx_in};
      g_s  <= {g_s[0], gate_in};
      a_sd <= a_s[1];
    end

  logic [PSC_W-1:0] div_n, psc_cnt;
  logic             tick;
  assign tick        = (psc_cnt == PSC_ZERO);
  assign sample_tick = tick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_n   <= PSC_ZERO;
      psc_cnt <= PSC_ZERO;
    end else if (psc_load) begin
      div_n   <= psc_value;
      psc_cnt <= psc_value;
    end else if (tick) begin
      psc_cnt <= div_n;
    end else begin
      psc_cnt <= psc_cnt - PSC_ONE;
    end

  assert_tick_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_n != PSC_ZERO && !psc_load) |=> !sample_tick);

  logic fa, fb, pend_a, pend_b, fa_q, fb_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fa <= 1'b0; fb <= 1'b0; pend_a <= 1'b0; pend_b <= 1'b0;
      fa_q <= 1'b0; fb_q <= 1'b0;
    end else begin
      fa_q <= fa;
      fb_q <= fb;
      if (tick) begin
        if (a_s[1] != fa) begin
          if (pend_a) begin fa <= a_s[1]; pend_a <= 1'b0; end
          else pend_a <= 1'b1;
        end else pend_a <= 1'b0;
        if (b_s[1] != fb) begin
          if (pend_b) begin fb <= b_s[1]; pend_b <= 1'b0; end
          else pend_b <= 1'b1;
        end else pend_b <= 1'b0;
      end
    end

  assign a_filt = fa;
  assign b_filt = fb;

  assert_filter_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> ($stable(a_filt) && $stable(b_filt)));

  logic quad, ch_a, ch_b, dbl, step, dir, allow, step_ok;
  assign quad  = (mode != 2'b00);
  assign ch_a  = fa ^ fa_q;
  assign ch_b  = fb ^ fb_q;
  assign allow = ab_enable & (~gate_mode | g_s[1]);

  always_comb begin
    step = 1'b0;
    dir  = cnt_up;
    dbl  = 1'b0;
    if (quad) begin
      if (ch_a && ch_b) dbl = 1'b1;
      else if (ch_a) begin
        dir  = fa ^ fb;
        step = mode[1] | ~fb;
      end else if (ch_b) begin
        dir  = ~(fa ^ fb);
        step = (mode == 2'b11);
      end
    end else begin
      step = a_s[1] & ~a_sd;
      dir  = b_s[1];
    end
  end

  assign step_ok = step & allow;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_en <= 1'b0;
      cnt_up <= 1'b1;
    end else begin
      cnt_en <= step_ok;
      if (step_ok) cnt_up <= dir;
    end

  assert_gate_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow) |=> !cnt_en);

  logic last_ch, last_v, err_set;
  assign err_set = quad & (dbl | (ch_a & last_v & ~last_ch) | (ch_b & last_v & last_ch));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      last_ch   <= 1'b0;
      last_v    <= 1'b0;
      noise_err <= 1'b0;
    end else begin
      if (!quad || dbl) last_v <= 1'b0;
      else if (ch_a) begin last_ch <= 1'b0; last_v <= 1'b1; end
      else if (ch_b) begin last_ch <= 1'b1; last_v <= 1'b1; end
      if (err_set) noise_err <= 1'b1;
      else if (err_clear) noise_err <= 1'b0;
    end

  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (noise_err && !err_clear) |=> noise_err);

  logic act, act_d, rise, syncm, armed, fire;
  assign act   = idx_pol ? i_s[1] : ~i_s[1];
  assign rise  = act & ~act_d;
  assign syncm = idx_sync & quad;
  assign fire  = syncm & act & (armed | rise) & step_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_d     <= 1'b0;
      armed     <= 1'b0;
      idx_pulse <= 1'b0;
    end else begin
      act_d     <= act;
      armed     <= act & (armed | rise) & ~fire;
      idx_pulse <= syncm ? fire : rise;
    end

  assert_idx_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_pulse && $past(syncm)) |=> !idx_pulse);

endmodule

// File: tb/quad_front_bench.sv
module quad_front_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psc_load = 1'b0;
  logic [7:0] psc_value = 8'd0;
  logic [1:0] mode = 2'b11;
  logic ab_enable = 1'b1, gate_mode = 1'b0, gate_in = 1'b0;
  logic a_in = 1'b0, b_in = 1'b0, idx_in = 1'b0, idx_pol = 1'b1, idx_sync = 1'b0;
  logic err_clear = 1'b0;
  logic sample_tick, a_filt, b_filt, cnt_en, cnt_up, idx_pulse, noise_err;

  always #5 clk = ~clk;

  quad_front #(.PSC_W(8)) u_quad_front (
    .clk(clk), .rst_n(rst_n), .psc_load(psc_load), .psc_value(psc_value),
    .mode(mode), .ab_enable(ab_enable), .gate_mode(gate_mode), .gate_in(gate_in),
    .a_in(a_in), .b_in(b_in), .idx_in(idx_in), .idx_pol(idx_pol),
    .idx_sync(idx_sync), .err_clear(err_clear), .sample_tick(sample_tick),
    .a_filt(a_filt), .b_filt(b_filt), .cnt_en(cnt_en), .cnt_up(cnt_up),
    .idx_pulse(idx_pulse), .noise_err(noise_err));

  int checks = 0, failures = 0;
  int ups = 0, downs = 0, idxs = 0, ticks = 0, cycles = 0;
  bit done = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural model state
  bit m_a1, m_a2, m_b1, m_b2, m_i1, m_i2, m_g1, m_g2, m_ad;
  int m_div, m_cnt;
  bit m_fa, m_fb, m_pa, m_pb, m_qa, m_qb;
  bit m_lch, m_lv, m_err, m_actd, m_arm, m_en, m_up = 1, m_idx;
  string cnt_tag = "R4", idx_tag = "R11";

  always @(posedge clk) begin
    bit tk, qd, ca, cb, db, st, dr, al, ok, es, ac, rs, sm, fr;
    int ncnt;
    if (!rst_n) begin
      {m_a1, m_a2, m_b1, m_b2, m_i1, m_i2, m_g1, m_g2, m_ad} = '0;
      m_div = 0; m_cnt = 0;
      {m_fa, m_fb, m_pa, m_pb, m_qa, m_qb, m_lch, m_lv, m_err, m_actd, m_arm, m_en, m_idx} = '0;
      m_up = 1;
    end else begin
      tk = (m_cnt == 0);
      qd = (mode != 0);
      ca = (m_fa != m_qa);
      cb = (m_fb != m_qb);
      db = 0; st = 0; dr = m_up;
      if (qd) begin
        if (ca && cb) db = 1;
        else if (ca) begin
          dr = (m_fa != m_fb);
          st = (mode == 3) || (mode == 2) || (mode == 1 && !m_fb);
        end else if (cb) begin
          dr = (m_fa == m_fb);
          st = (mode == 3);
        end
      end else begin
        st = m_a2 && !m_ad;
        dr = m_b2;
      end
      al = ab_enable && (!gate_mode || m_g2);
      ok = st && al;
      cnt_tag = !al ? "R8" : (mode == 0) ? "R7" : (mode == 1) ? "R6" : (mode == 2) ? "R5" : "R4";
      es = qd && (db || (ca && m_lv && m_lch == 0) || (cb && m_lv && m_lch == 1));
      if (es) m_err = 1; else if (err_clear) m_err = 0;
      if (!qd || db) m_lv = 0;
      else if (ca) begin m_lch = 0; m_lv = 1; end
      else if (cb) begin m_lch = 1; m_lv = 1; end
      ac = idx_pol ? m_i2 : !m_i2;
      rs = ac && !m_actd;
      sm = idx_sync && qd;
      fr = sm && ac && (m_arm || rs) && ok;
      idx_tag = sm ? "R10" : "R11";
      m_arm = ac && (m_arm || rs) && !fr;
      m_actd = ac;
      m_idx = sm ? fr : rs;
      m_en = ok;
      if (ok) m_up = dr;
      m_qa = m_fa; m_qb = m_fb;
      if (tk) begin
        if (m_a2 != m_fa) begin if (m_pa) begin m_fa = m_a2; m_pa = 0; end else m_pa = 1; end
        else m_pa = 0;
        if (m_b2 != m_fb) begin if (m_pb) begin m_fb = m_b2; m_pb = 0; end else m_pb = 1; end
        else m_pb = 0;
      end
      m_ad = m_a2;
      m_a2 = m_a1; m_a1 = a_in;
      m_b2 = m_b1; m_b1 = b_in;
      m_i2 = m_i1; m_i1 = idx_in;
      m_g2 = m_g1; m_g1 = gate_in;
      if (psc_load) ncnt = psc_value;
      else if (tk) ncnt = m_div;
      else ncnt = m_cnt - 1;
      if (psc_load) m_div = psc_value;
      m_cnt = ncnt;
    end
    #1;
    if (rst_n && !done) begin
      cycles++;
      check("R2 sample_tick", sample_tick, m_cnt == 0);
      check("R3 a_filt", a_filt, m_fa);
      check("R3 b_filt", b_filt, m_fb);
      check({cnt_tag, " cnt_en"}, cnt_en, m_en);
      check({cnt_tag, " cnt_up"}, cnt_up, m_up);
      check({idx_tag, " idx_pulse"}, idx_pulse, m_idx);
      check("R9 noise_err", noise_err, m_err);
      if (cnt_en && cnt_up) ups++;
      if (cnt_en && !cnt_up) downs++;
      if (idx_pulse) idxs++;
      if (sample_tick) ticks++;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ab(bit a, bit b, int hold);
    a_in = a; b_in = b;
    idle(hold);
  endtask

  task automatic fwd(int n, int hold);
    for (int k = 0; k < n; k++) begin
      case ({a_in, b_in})
        2'b00: ab(1, 0, hold);
        2'b10: ab(1, 1, hold);
        2'b11: ab(0, 1, hold);
        default: ab(0, 0, hold);
      endcase
    end
  endtask

  task automatic rev(int n, int hold);
    for (int k = 0; k < n; k++) begin
      case ({a_in, b_in})
        2'b00: ab(0, 1, hold);
        2'b01: ab(1, 1, hold);
        2'b11: ab(1, 0, hold);
        default: ab(0, 0, hold);
      endcase
    end
  endtask

  task automatic load_psc(int n);
    psc_value = 8'(n); psc_load = 1'b1;
    idle(1);
    psc_load = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    int u0, d0, x0, t0;
    idle(3);
    check("R1 cnt_en", cnt_en, 0);
    check("R1 idx_pulse", idx_pulse, 0);
    check("R1 noise_err", noise_err, 0);
    check("R1 cnt_up", cnt_up, 1);
    check("R1 a_filt", a_filt, 0);
    check("R1 b_filt", b_filt, 0);
    check("R1 sample_tick", sample_tick, 1);
    rst_n = 1'b1;
    idle(4);

    u0 = ups; fwd(8, 6); check("R4 x4 forward ups", ups - u0, 8);
    d0 = downs; rev(4, 6); check("R4 x4 reverse downs", downs - d0, 4);

    u0 = ups; d0 = downs;
    a_in = 1; idle(1); a_in = 0; idle(8);
    check("R3 narrow glitch ups", ups - u0, 0);
    check("R3 narrow glitch downs", downs - d0, 0);

    ab(1, 0, 6); ab(0, 0, 6);
    check("R9 toggle back sets error", noise_err, 1);
    err_clear = 1; idle(1); err_clear = 0; idle(2);
    check("R9 clear", noise_err, 0);
    ab(1, 1, 8);
    check("R9 double change sets error", noise_err, 1);
    ab(0, 0, 8);
    err_clear = 1; idle(1); err_clear = 0; idle(2);

    mode = 2'b10; idle(2);
    u0 = ups; fwd(4, 6); check("R5 x2 forward ups", ups - u0, 2);
    mode = 2'b01; idle(2);
    u0 = ups; fwd(4, 6); check("R6 x1 forward ups", ups - u0, 1);
    d0 = downs; rev(4, 6); check("R6 x1 reverse downs", downs - d0, 1);

    mode = 2'b11;
    load_psc(3); idle(8);
    u0 = ups; fwd(4, 24); check("R2 divided rate x4 ups", ups - u0, 4);
    u0 = ups; a_in = 1; idle(3); a_in = 0; idle(24);
    check("R3 short glitch at slow rate", ups - u0, 0);

    psc_value = 8'd255; psc_load = 1'b1; idle(1); psc_load = 1'b0;
    t0 = ticks; idle(511);
    check("R2 strobes after n=255", ticks - t0, 2);
    load_psc(0); idle(4);

    gate_mode = 1; gate_in = 0; idle(4);
    u0 = ups; fwd(4, 6); check("R8 gate low blocks", ups - u0, 0);
    gate_in = 1; idle(4);
    u0 = ups; fwd(4, 6); check("R8 gate high counts", ups - u0, 4);
    gate_mode = 0; ab_enable = 0; idle(2);
    u0 = ups; fwd(4, 6); check("R8 disabled inputs", ups - u0, 0);
    ab_enable = 1; idle(2);

    mode = 2'b00; b_in = 1; idle(4);
    u0 = ups;
    for (int k = 0; k < 3; k++) begin a_in = 1; idle(3); a_in = 0; idle(3); end
    check("R7 bypass up pulses", ups - u0, 3);
    b_in = 0; idle(4);
    d0 = downs;
    for (int k = 0; k < 2; k++) begin a_in = 1; idle(1); a_in = 0; idle(2); end
    check("R7 bypass down pulses", downs - d0, 2);

    mode = 2'b11; idx_sync = 1; idle(8);
    x0 = idxs;
    ab(1, 0, 6); idx_in = 1; ab(1, 1, 6); idx_in = 0; ab(0, 1, 6); ab(0, 0, 6);
    check("R10 quarter-cycle index", idxs - x0, 1);
    x0 = idxs;
    idx_in = 1; ab(1, 0, 6); ab(1, 1, 6); idx_in = 0; ab(0, 1, 6); ab(0, 0, 6);
    check("R10 half-cycle index", idxs - x0, 1);
    idx_sync = 0; idx_in = 1; idle(6); idx_pol = 0; idle(6); idx_sync = 1; idle(2);
    x0 = idxs;
    ab(1, 0, 6); idx_in = 0; ab(1, 1, 6); idx_in = 1; ab(0, 1, 6); ab(0, 0, 6);
    check("R10 active-low index", idxs - x0, 1);

    idx_sync = 0; idle(4);
    x0 = idxs; idx_in = 0; idle(2); idx_in = 1; idle(6);
    check("R11 unsynchronized index", idxs - x0, 1);
    mode = 2'b00; idx_sync = 1; idle(4);
    x0 = idxs; idx_in = 0; idle(2); idx_in = 1; idle(6);
    check("R11 bypass ignores sync", idxs - x0, 1);

    idle(4);
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    summary();
  end
endmodule